// File: doc/BRIEF.md
# Circular buffer address updater

This unit moves a pointer by a signed offset and keeps the result inside a circular buffer. The buffer is described by a 32-bit modifier word and a separate base register. The modifier word holds a window-size code and a buffer length. Together these select one of two ways to place the window. In the first, the base register gives an explicit start and the window runs for the length in bytes. In the second, the window start is the pointer rounded down to a power-of-two boundary, and the window end is that start with the length OR-ed in.

The unit has a single register stage. An address-generation stage of a load/store pipe presents the pointer, offset, modifier and base together with a valid strobe. One cycle later the unit returns the wrapped pointer with its own valid strobe. The memory access that consumes the pointer is not part of this block.

Top module: `circ_ptr_update`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out_valid` is 0 and `out_ptr` is 0.
- R2: `out_valid` is 1 exactly one clock after a cycle in which `in_valid` is 1, and 0 otherwise. `out_ptr` is loaded only on a cycle with `in_valid` = 1 and otherwise keeps its value.
- R3: Window code k is bits 27:24 of `modifier`, read as signed. Length L is bits 16:0 of `modifier`, read as signed and sign-extended to 32 bits. When k = 0 and L >= 4 (signed), the window start is `base` and the window end is `base + L` (modulo 2^32).
- R4: In every other case the mask is 2^(k+2) - 1 when k+2 >= 1, and 0 when k+2 <= 0. The start is `ptr` with the mask bits cleared, and the end is the start OR-ed with L.
- R5: The sum is `ptr + offset` modulo 2^32, with `offset` taken as a two's-complement value. If the sum is >= the end, the result is the sum minus L.
- R6: If the sum is below the start and R5 did not apply, the result is the sum plus L. When both conditions hold in the same cycle, R5 takes priority.
- R7: If neither wrap condition holds, the result equals the sum.
- R8: All start and end comparisons are unsigned 32-bit. A sum at or above 0x80000000 counts as larger than any smaller address.
- R9: When k = 0 and L < 4, the window follows R4 with a mask of 3, not R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands below are valid this cycle |
| ptr | input | 32 | Current pointer |
| offset | input | 32 | Signed increment |
| modifier | input | 32 | Window code (27:24) and length (16:0) |
| base | input | 32 | Explicit window start |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_ptr | output | 32 | Updated, wrapped pointer |

## Verification
Both wrap conditions can be true at once. This happens when the explicit window crosses the top of the address space, so that its end computes below its start. The bench sets this up with a base near 0xFFFFFF00 and a sum that lands between the wrapped end and the start. It then checks that the length is subtracted (R5) and not added. Random modifiers with small and negative lengths, including signed window codes, reach the same overlap without being steered. Each result is judged against a bench function that applies R5 before R6.

// File: rtl/circ_ptr_update.sv
module circ_ptr_update #(
  parameter int AW     = 32,
  parameter int KW     = 4,
  parameter int KLSB   = 24,
  parameter int LW     = 17,
  parameter int LLSB   = 0,
  parameter int MINLEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] modifier,
  input  logic [AW-1:0] base,
  output logic          out_valid,
  output logic [AW-1:0] out_ptr
);

  localparam int SW = KW + 1;

  logic [KW-1:0] k_fld;
  logic [AW-1:0] len;
  logic [SW-1:0] shamt;
  logic          explicit_win;
  logic [AW-1:0] mask, win_lo, win_hi, sum, nxt;
  logic          wrap_hi, wrap_lo;

  assign k_fld  = modifier[KLSB +: KW];
  assign len    = {{(AW-LW){modifier[LLSB+LW-1]}}, modifier[LLSB +: LW]};
  assign shamt  = {k_fld[KW-1], k_fld} + SW'(2);

  assign explicit_win = (k_fld == '0) && ($signed(len) >= MINLEN);

  assign mask   = ($signed(shamt) > 0) ? ((AW'(1) << shamt) - AW'(1)) : '0;
  assign win_lo = explicit_win ? base : (ptr & ~mask);
  assign win_hi = explicit_win ? (win_lo + len) : (win_lo | len);

  assign sum     = ptr + offset;
  assign wrap_hi = (sum >= win_hi);
  assign wrap_lo = (sum < win_lo);
  assign nxt     = wrap_hi ? (sum - len) : (wrap_lo ? (sum + len) : sum);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ptr   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_ptr <= nxt;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R2
  AST_HOLD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_ptr));  // R2
  AST_HI_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wrap_hi) |=> (out_ptr + $past(len) == $past(sum)));  // R5
  AST_LO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wrap_lo && !wrap_hi) |=> (out_ptr - $past(len) == $past(sum)));  // R6

endmodule

// File: tb/tb_circ_ptr_update.sv
module tb_circ_ptr_update;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] ptr = '0, offset = '0, modifier = '0, base = '0;
  logic        out_valid;
  logic [31:0] out_ptr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_ptr_update dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ptr(ptr), .offset(offset),
    .modifier(modifier), .base(base), .out_valid(out_valid), .out_ptr(out_ptr)
  );

  function automatic logic [31:0] expect_ptr(input logic [31:0] p, input logic [31:0] o,
                                             input logic [31:0] m, input logic [31:0] b);
    int k;
    int l;
    logic [31:0] lv, msk, lo, hi, s;
    k  = int'($signed(m[27:24]));
    l  = int'($signed(m[16:0]));
    lv = 32'(l);
    s  = p + o;
    if (k == 0 && l >= 4) begin
      lo = b;
      hi = b + lv;
    end else begin
      msk = (k + 2 >= 1) ? ((32'd1 << (k + 2)) - 32'd1) : 32'd0;
      lo  = p & ~msk;
      hi  = lo | lv;
    end
    if (s >= hi)      return s - lv;   // R5 first
    else if (s < lo)  return s + lv;   // R6
    else              return s;        // R7
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [31:0] p, input logic [31:0] o,
                        input logic [31:0] m, input logic [31:0] b);
    logic [31:0] e;
    e = expect_ptr(p, o, m, b);
    @(negedge clk);
    in_valid = 1'b1; ptr = p; offset = o; modifier = m; base = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, out_ptr, e);
  endtask

  initial begin
    logic [31:0] held;
    logic [31:0] m;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 ptr", out_ptr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", {31'd0, out_valid}, 32'd0);

    run_op("R3 R5 explicit upper", 32'h1000, 32'h120, 32'h0000_0100, 32'h1000);
    check("R5 value", out_ptr, 32'h1020);
    run_op("R3 R6 explicit lower", 32'h1000, -32'sd16, 32'h0000_0100, 32'h1000);
    check("R6 value", out_ptr, 32'h10F0);
    run_op("R7 passthrough", 32'h1000, 32'h50, 32'h0000_0100, 32'h1000);
    check("R7 value", out_ptr, 32'h1050);
    run_op("R4 legacy k3", 32'h2008, 32'h10, 32'h0300_0014, 32'h0);
    check("R4 value", out_ptr, 32'h2004);
    run_op("R9 k0 short len", 32'h101, 32'h2, 32'h0000_0003, 32'h5000);
    check("R9 value", out_ptr, 32'h100);
    run_op("R8 unsigned compare", 32'h7FFF_FFF8, 32'h40, 32'h0000_0040, 32'h7FFF_FFF0);
    check("R8 value", out_ptr, 32'h7FFF_FFF8);
    run_op("R6 negative len legacy", 32'h100, 32'hFFFF_FFF8, 32'h0101_FFF0, 32'h0);
    check("R6 neg len value", out_ptr, 32'hE8);
    run_op("R5 R6 both true", 32'h0, 32'h180, 32'h0000_0200, 32'hFFFF_FF00);
    check("R5 priority value", out_ptr, 32'hFFFF_FF80);
    run_op("R4 negative k", 32'h3456, 32'h10, 32'h0D00_0020, 32'h0);

    held = out_ptr;
    @(negedge clk);
    ptr = 32'hDEAD_0000; offset = 32'h1234; modifier = 32'h0000_0100;
    @(negedge clk);
    check("R2 idle valid", {31'd0, out_valid}, 32'd0);
    check("R2 hold ptr", out_ptr, held);

    for (int i = 0; i < 2000; i++) begin
      m = $urandom;
      if (i % 3 == 0) m[27:24] = 4'd0;
      if (i % 5 == 0) m[16:0] = 17'($urandom_range(0, 8));
      run_op("R3 R4 R5 R6 R7 random", $urandom, ((i % 2) != 0) ? 32'($urandom_range(0, 512)) - 32'd256 : $urandom, m, $urandom);
    end

    @(negedge clk);
    @(negedge clk);
    check("R2 valid drops", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule